// File: doc/BRIEF.md
# Tone Transceiver Host Register Bank

This block is the host-facing register bank of a tone transceiver. A host reaches it over a 4-bit data bus with an active-low chip select, separate active-low read and write strobes, and a single register-select line. Each clock cycle in which the chip select and a strobe are both low counts as one access. Register select 0 is the data address. A read there returns the code of the most recently validated received digit. A write there loads the transmit digit code, which picks the tone pair the transmitter sends. Register select 1 is the control address. A read there returns status. Writes there go to one of two control registers, and both of those registers live at this single address.

After reset, every write to the control address lands in control A. If a write to control A has bit 3 set, the bank arms a redirect. The next control write then lands in control B and disarms the redirect, and control writes after that go to control A again. Detector and transmitter events arrive as single-cycle pulses and are latched as flags. The host clears the flags by reading status. A shared open-drain pin carries either the interrupt or a call-progress square wave, and a control bit chooses which. Its pull-down enable is an output, and its data output is tied low.

Top module: `tone_host_regs`

## Requirements
- R1: After reset, control A, control B, the transmit code, the received code and all flags read as zero, the redirect is disarmed, and the pin enable is off.
- R2: A write at select 0 sets the transmit code output to the written value. A read at select 0 returns the received code.
- R3: The received code takes rx_code only in a cycle with rx_valid high. It holds its value otherwise, including across host writes at select 0.
- R4: A control write while the redirect is disarmed loads control A and leaves control B unchanged. If bit 3 of the written value is 1, the write arms the redirect.
- R5: A control write while the redirect is armed loads control B, leaves control A unchanged and disarms the redirect, so the next control write goes to control A.
- R6: Writes at select 0 and status reads leave the redirect state unchanged.
- R7: The status read has this layout: bit 0 is the interrupt-pending state, bit 1 is the transmitter-ready flag, bit 2 is the digit-received flag, and bit 3 is the armed redirect.
- R8: Interrupt pending is the AND of control A bit 0 with the digit flag OR'd with the transmitter flag. The transmitter flag counts only when control A bit 2 (burst mode) is set. When control A bit 1 is 0, the pin enable equals interrupt pending.
- R9: A status read clears both flags at the clock edge that ends it. An event pulse in that same cycle wins, and its flag stays set.
- R10: When control A bit 1 is 1, the pin enable is the inverse of cp_in. The pin data output is always 0.
- R11: A strobe with cs_n high changes no register, and it does not enable read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| rs | input | 1 | Register select: 0 data, 1 control/status |
| wdata | input | 4 | Host write data |
| rdata | output | 4 | Host read data |
| rdata_oe | output | 1 | Read data valid / bus drive enable |
| rx_valid | input | 1 | Single-cycle pulse: a digit was validated |
| rx_code | input | 4 | Code of the validated digit |
| tx_ready | input | 1 | Single-cycle pulse: the transmitter can take more data |
| cp_in | input | 1 | Call-progress square wave |
| tx_code | output | 4 | Transmit digit code |
| ctl_a | output | 4 | Control A contents |
| ctl_b | output | 4 | Control B contents |
| irq_n_o | output | 1 | Pin data, always low |
| irq_oe | output | 1 | Pin pull-down enable |

## Verification
The hardest cases to reach are the redirect's interaction with the other traffic, and a status read that clears the flags in the same cycle that a new event arrives. The stimulus sweeps every pair of control A and control B values through the arm-then-redirect sequence. It places data writes and status reads between arming and the redirected write. It also drives an rx_valid pulse in exactly the cycle that holds the status read. The pin is swept over every combination of enable, burst and call-progress mode, every event mix, and both levels of cp_in.

// File: rtl/tone_regs_pkg.sv
package tone_regs_pkg;
  localparam int unsigned DW = 4;
  // control A bit positions
  localparam int unsigned A_IRQ_EN = 0;
  localparam int unsigned A_CP_SEL = 1;
  localparam int unsigned A_BURST  = 2;
  localparam int unsigned A_REDIR  = 3;
  // status bit positions
  localparam int unsigned S_PEND  = 0;
  localparam int unsigned S_TXF   = 1;
  localparam int unsigned S_RXF   = 2;
  localparam int unsigned S_ARMED = 3;
  localparam logic SEL_DATA = 1'b0;
  localparam logic SEL_CTRL = 1'b1;
  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_data;
    logic rd_stat;
  } bus_op_t;
endpackage

// File: rtl/tone_bus_decode.sv
module tone_bus_decode
  import tone_regs_pkg::*;
(
  input  logic    cs_n,
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    rs,
  output bus_op_t op
);
  logic sel, wr, rd;
  always_comb begin
    sel = ~cs_n;
    wr  = sel & ~wr_n;
    rd  = sel & ~rd_n & wr_n;  // write wins if both strobes are low
    op.wr_data = wr & (rs == SEL_DATA);
    op.wr_ctrl = wr & (rs == SEL_CTRL);
    op.rd_data = rd & (rs == SEL_DATA);
    op.rd_stat = rd & (rs == SEL_CTRL);
  end
endmodule

// File: rtl/tone_ctrl_bank.sv
module tone_ctrl_bank
  import tone_regs_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_ctrl,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] ctl_a,
  output logic [W-1:0] ctl_b,
  output logic         armed
);
  logic         a_en, b_en, armed_d;

  always_comb begin
    a_en    = wr_ctrl & ~armed;
    b_en    = wr_ctrl & armed;
    armed_d = armed;
    if (a_en)      armed_d = wdata[A_REDIR];
    else if (b_en) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_a <= '0;
      ctl_b <= '0;
      armed <= 1'b0;
    end else begin
      if (a_en) ctl_a <= wdata;
      if (b_en) ctl_b <= wdata;
      armed <= armed_d;
    end
  end
endmodule

// File: rtl/tone_event_flags.sv
module tone_event_flags
  import tone_regs_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_code,
  input  logic         tx_ready,
  input  logic         rd_stat,
  input  logic         irq_en,
  input  logic         burst,
  output logic [W-1:0] rx_q,
  output logic         rx_flag,
  output logic         tx_flag,
  output logic         irq_pend
);
  logic rx_flag_d, tx_flag_d;

  always_comb begin
    rx_flag_d = rx_valid | (rx_flag & ~rd_stat);
    tx_flag_d = tx_ready | (tx_flag & ~rd_stat);
    irq_pend  = irq_en & (rx_flag | (burst & tx_flag));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_q    <= '0;
      rx_flag <= 1'b0;
      tx_flag <= 1'b0;
    end else begin
      if (rx_valid) rx_q <= rx_code;
      rx_flag <= rx_flag_d;
      tx_flag <= tx_flag_d;
    end
  end
endmodule

// File: rtl/tone_host_regs.sv
module tone_host_regs
  import tone_regs_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cs_n,
  input  logic         rd_n,
  input  logic         wr_n,
  input  logic         rs,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         rdata_oe,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_code,
  input  logic         tx_ready,
  input  logic         cp_in,
  output logic [W-1:0] tx_code,
  output logic [W-1:0] ctl_a,
  output logic [W-1:0] ctl_b,
  output logic         irq_n_o,
  output logic         irq_oe
);
  logic         rst_m, rst_s;
  bus_op_t      op;
  logic         wr_ctrl, rd_stat;
  logic         armed;
  logic [W-1:0] rx_q;
  logic         rx_flag, tx_flag, irq_pend;
  logic [W-1:0] status;

  // reset: asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  tone_bus_decode u_dec (
    .cs_n (cs_n),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .rs   (rs),
    .op   (op)
  );

  assign wr_ctrl = op.wr_ctrl;
  assign rd_stat = op.rd_stat;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)          tx_code <= '0;
    else if (op.wr_data) tx_code <= wdata;
  end

  tone_ctrl_bank #(.W(W)) u_ctl (
    .clk     (clk),
    .rst_n   (rst_s),
    .wr_ctrl (wr_ctrl),
    .wdata   (wdata),
    .ctl_a   (ctl_a),
    .ctl_b   (ctl_b),
    .armed   (armed)
  );

  tone_event_flags #(.W(W)) u_evt (
    .clk      (clk),
    .rst_n    (rst_s),
    .rx_valid (rx_valid),
    .rx_code  (rx_code),
    .tx_ready (tx_ready),
    .rd_stat  (rd_stat),
    .irq_en   (ctl_a[A_IRQ_EN]),
    .burst    (ctl_a[A_BURST]),
    .rx_q     (rx_q),
    .rx_flag  (rx_flag),
    .tx_flag  (tx_flag),
    .irq_pend (irq_pend)
  );

  always_comb begin
    status          = '0;
    status[S_PEND]  = irq_pend;
    status[S_TXF]   = tx_flag;
    status[S_RXF]   = rx_flag;
    status[S_ARMED] = armed;
    rdata_oe = op.rd_data | op.rd_stat;
    if (op.rd_stat)      rdata = status;
    else if (op.rd_data) rdata = rx_q;
    else                 rdata = '0;
    irq_n_o = 1'b0;
    irq_oe  = ctl_a[A_CP_SEL] ? ~cp_in : irq_pend;
  end
endmodule

// File: rtl/tone_host_regs_chk.sv
module tone_host_regs_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_ok,
  input logic         cs_n,
  input logic         wr_ctrl,
  input logic         rd_stat,
  input logic [W-1:0] wdata,
  input logic [W-1:0] ctl_a,
  input logic [W-1:0] ctl_b,
  input logic [W-1:0] tx_code,
  input logic         armed,
  input logic         rx_valid,
  input logic [W-1:0] rx_code,
  input logic [W-1:0] rx_q,
  input logic         tx_ready,
  input logic         irq_pend
);
  // R4
  ctla_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctrl && !armed) |=> (ctl_a == $past(wdata)) && $stable(ctl_b));
  // R5
  ctlb_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_ctrl && armed) |=> (ctl_b == $past(wdata)) && $stable(ctl_a) && !armed);
  // R3
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !rx_valid |=> $stable(rx_q));
  // R3
  rx_take_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    rx_valid |=> (rx_q == $past(rx_code)));
  // R11
  no_select_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    cs_n |=> $stable(ctl_a) && $stable(ctl_b) && $stable(tx_code) && $stable(armed));
  // R9
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (rd_stat && !rx_valid && !tx_ready) |=> !irq_pend);
endmodule

bind tone_host_regs tone_host_regs_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_ok   (rst_s),
  .cs_n     (cs_n),
  .wr_ctrl  (wr_ctrl),
  .rd_stat  (rd_stat),
  .wdata    (wdata),
  .ctl_a    (ctl_a),
  .ctl_b    (ctl_b),
  .tx_code  (tx_code),
  .armed    (armed),
  .rx_valid (rx_valid),
  .rx_code  (rx_code),
  .rx_q     (rx_q),
  .tx_ready (tx_ready),
  .irq_pend (irq_pend)
);

// File: tb/sim_tone_host_regs.sv
`timescale 1ns/1ps
module sim_tone_host_regs;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cs_n, rd_n, wr_n, rs;
  logic [3:0] wdata, rdata, rx_code, tx_code, ctl_a, ctl_b;
  logic       rdata_oe, rx_valid, tx_ready, cp_in, irq_n_o, irq_oe;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  tone_host_regs u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n), .rs(rs),
    .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe), .rx_valid(rx_valid),
    .rx_code(rx_code), .tx_ready(tx_ready), .cp_in(cp_in), .tx_code(tx_code),
    .ctl_a(ctl_a), .ctl_b(ctl_b), .irq_n_o(irq_n_o), .irq_oe(irq_oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic sel, input logic [3:0] d);
    @(negedge clk); cs_n = 0; wr_n = 0; rs = sel; wdata = d;
    @(negedge clk); cs_n = 1; wr_n = 1;
  endtask

  task automatic bus_rd(input logic sel, output logic [3:0] d);
    @(negedge clk); cs_n = 0; rd_n = 0; rs = sel;
    #1 d = rdata;
    @(negedge clk); cs_n = 1; rd_n = 1;
  endtask

  task automatic pulse(input logic rxv, input logic txr, input logic [3:0] code);
    @(negedge clk); rx_valid = rxv; tx_ready = txr; rx_code = code;
    @(negedge clk); rx_valid = 0; tx_ready = 0;
  endtask

  initial begin
    #(200000 * 8);
    chk(1'b0, "watchdog", 0, 1);
    if (!done) begin
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [3:0] d;
    logic       exp_irq;
    cs_n = 1; rd_n = 1; wr_n = 1; rs = 0; wdata = 0;
    rx_valid = 0; rx_code = 0; tx_ready = 0; cp_in = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(ctl_a == 0 && ctl_b == 0 && tx_code == 0, "R1 regs", {ctl_a, ctl_b, tx_code}, 0);
    chk(irq_oe == 0 && irq_n_o == 0, "R1 pin", irq_oe, 0);
    bus_rd(1, d); chk(d == 0, "R1 status", d, 0);
    bus_rd(0, d); chk(d == 0, "R1 rx", d, 0);

    // R2 transmit sweep, R3 rx held across data writes
    for (int v = 0; v < 16; v++) begin
      bus_wr(0, 4'(v));
      chk(tx_code == 4'(v), "R2 tx", tx_code, v);
      bus_rd(0, d); chk(d == 0, "R3 rx hold", d, 0);
    end
    // R2/R3 receive sweep
    for (int v = 0; v < 16; v++) begin
      pulse(1, 0, 4'(v));
      rx_code = 4'(15 - v);
      repeat (2) @(negedge clk);
      bus_rd(0, d); chk(d == 4'(v), "R3 rx take", d, v);
    end
    bus_rd(1, d);  // clear flags

    // R4/R5 every pair through the redirect sequence
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        bus_wr(1, 4'(a) | 4'h8);
        chk(ctl_a == (4'(a) | 4'h8), "R4 load A", ctl_a, a | 8);
        bus_wr(1, 4'(b));
        chk(ctl_b == 4'(b) && ctl_a == (4'(a) | 4'h8), "R5 load B", {ctl_a, ctl_b}, {4'(a) | 4'h8, 4'(b)});
        bus_wr(1, 4'(a) & 4'h7);
        chk(ctl_a == (4'(a) & 4'h7) && ctl_b == 4'(b), "R5 back to A", {ctl_a, ctl_b}, {4'(a) & 4'h7, 4'(b)});
      end
    end
    // R4 unarmed writes with bit3 clear never reach B
    bus_wr(1, 4'h0); bus_wr(1, 4'h5);
    chk(ctl_a == 4'h5 && ctl_b == 4'hf, "R4 no arm", {ctl_a, ctl_b}, 8'h5f);

    // R6/R7 arm survives data writes and status reads
    bus_wr(1, 4'h8);
    bus_wr(0, 4'h3);
    bus_rd(1, d); chk(d == 4'h8, "R7 armed bit", d, 8);
    bus_rd(0, d);
    bus_wr(1, 4'h6);
    chk(ctl_b == 4'h6 && ctl_a == 4'h8, "R6 arm kept", {ctl_a, ctl_b}, 8'h86);
    bus_rd(1, d); chk(d == 4'h0, "R7 disarmed", d, 0);

    // R11 strobes without select
    @(negedge clk); cs_n = 1; wr_n = 0; rs = 1; wdata = 4'h9;
    @(negedge clk); rs = 0;
    @(negedge clk); wr_n = 1; rd_n = 0; #1
    chk(rdata_oe == 0, "R11 no oe", rdata_oe, 0);
    @(negedge clk); rd_n = 1;
    chk(ctl_a == 4'h8 && ctl_b == 4'h6 && tx_code == 4'h3, "R11 no write", {ctl_a, ctl_b, tx_code}, 12'h863);

    // R7/R8/R9/R10 pin matrix
    for (int m = 0; m < 64; m++) begin
      logic en, cp, bu, erx, etx, cpl;
      en = m[0]; cp = m[1]; bu = m[2]; erx = m[3]; etx = m[4]; cpl = m[5];
      bus_wr(1, {1'b0, bu, cp, en});
      bus_rd(1, d);
      cp_in = cpl;
      pulse(erx, etx, 4'h1);
      exp_irq = en & (erx | (bu & etx));
      chk(irq_oe == (cp ? ~cpl : exp_irq), cp ? "R10 cp pin" : "R8 irq pin", irq_oe, cp ? ~cpl : exp_irq);
      chk(irq_n_o == 0, "R10 pin low", irq_n_o, 0);
      bus_rd(1, d);
      chk(d == {1'b0, erx, etx, exp_irq}, "R7 status", d, {1'b0, erx, etx, exp_irq});
      chk(irq_oe == (cp ? ~cpl : 1'b0), "R9 cleared", irq_oe, cp ? ~cpl : 1'b0);
    end

    // R9 event in the clearing cycle wins
    bus_wr(1, 4'h1);
    @(negedge clk); cs_n = 0; rd_n = 0; rs = 1; rx_valid = 1; rx_code = 4'hc;
    @(negedge clk); cs_n = 1; rd_n = 1; rx_valid = 0;
    chk(irq_oe == 1, "R9 set wins pin", irq_oe, 1);
    bus_rd(1, d); chk(d == 4'h5, "R9 set wins status", d, 5);
    bus_rd(1, d); chk(d == 4'h0, "R9 then clear", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule